// File: doc/BRIEF.md
# Speculative Load Survival Table

This block keeps track of loads that a compiler has hoisted above earlier stores. When such a load executes early, the pipeline writes the load's destination register id and a compressed form of its physical address into the table. Every later store presents its address and size. Any recorded load whose bytes the store might touch is dropped from the table. When the hoisted load reaches its original place in program order, the pipeline asks whether the entry for its destination register survived. A negative answer means the early value may be stale, and the load has to be issued again.

The table has 2^IDX_W slots, 32 by default. A slot is chosen by the low IDX_W bits of the destination register id. The remaining register-id bits are stored with the entry and compared on every check.

Each entry holds only a partial address: a TAG_W-bit slice of the 8-byte granule number plus a byte mask within that granule. Address bits above the slice are discarded. Two different addresses can therefore look alike, which may remove an entry that was never in conflict. A real conflict is never missed.

A clear input empties the whole table, for example on a context switch.

Top module: `spec_load_table`

## Requirements
- R1: After reset, every slot is invalid, so a check of any register id reports `chk_ok_o`=0.
- R2: A check issued in cycle N (`chk_valid_i`=1) is answered in cycle N+1 with `chk_done_o`=1. `chk_ok_o`=1 if the register id was recorded in an earlier cycle and has not been removed since.
- R3: The slot index is the low IDX_W bits of the register id, and the upper REG_W-IDX_W bits are stored and compared. A check of a register id that was never loaded misses, including one that shares a slot index with a live entry (for example 37 versus 5 when IDX_W=5).
- R4: A new advanced load to a register id that already has an entry replaces that entry's address and size. After that, only stores that overlap the new address remove it.
- R5: A store removes an entry only when both conditions hold:
  - the granule tags are equal, where the tag is address bits [TAG_W+2:3];
  - the two byte masks within the 8-byte granule share at least one byte.

  A store to other bytes of the same granule, or to a different granule, leaves the entry valid.
- R6: Address bits at and above bit TAG_W+3 are not compared. A store that differs from a recorded load only in those bits removes the entry.
- R7: The size code selects the access width: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. The access is aligned down to its own width, so the byte mask is 2^size bytes starting at offset `addr[2:0]` rounded down to a multiple of 2^size.
- R8: When a store removes an entry in the same cycle as a check of that entry, the check reports a miss.
- R9: Same-cycle rules:
  - a load and a store in the same cycle leave the new load's entry valid, because the store only affects older entries;
  - a check in the same cycle as a load to the same register sees the state before that load.
- R10: `clear_i` removes every entry. A check in the same cycle as the clear misses, and a load in the same cycle as the clear is also discarded.
- R11: A store removes only the entries it overlaps, and all other entries stay valid.
- R12: `chk_done_o` is 1 exactly in the cycle after a cycle with `chk_valid_i`=1, and `chk_ok_o` is 0 whenever `chk_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Invalidate all entries |
| ld_valid_i | input | 1 | Advanced load is recorded this cycle |
| ld_reg_i | input | REG_W | Destination register id of the advanced load |
| ld_addr_i | input | ADDR_W | Physical address of the advanced load |
| ld_size_i | input | 2 | Load size code (0:1B, 1:2B, 2:4B, 3:8B) |
| sto_valid_i | input | 1 | Store is presented this cycle |
| sto_addr_i | input | ADDR_W | Physical address of the store |
| sto_size_i | input | 2 | Store size code |
| chk_valid_i | input | 1 | Check request this cycle |
| chk_reg_i | input | REG_W | Register id being checked |
| chk_done_o | output | 1 | Check answer is valid this cycle |
| chk_ok_o | output | 1 | Entry survived, so the early load value may be used |

## Verification
On every cycle, the assertions check the following:
- the answer arrives exactly one cycle after each check (R12);
- a load followed at once by a clean check hits (R2);
- a store at the loaded address in the same cycle as the check forces a miss (R8);
- a clear forces misses (R10).

The bench scenarios cover the rest:
- the byte-mask and alignment rules for each size code (R5, R7);
- aliasing through the dropped upper address bits (R6);
- slot sharing between register ids (R3);
- overwrites (R4);
- selective removal (R11).

These behaviours depend on the history of several earlier operations, so a single-cycle property cannot express them.

// File: rtl/spec_load_pkg.sv
package spec_load_pkg;

    localparam int GRAN_LG = 3;
    localparam int GRAN_BYTES = 1 << GRAN_LG;

    typedef logic [GRAN_BYTES-1:0] byte_mask_t;

    // Byte lanes touched inside an 8-byte granule by an access that is
    // aligned down to its own width.
    function automatic byte_mask_t lane_mask(input logic [GRAN_LG-1:0] off,
                                             input logic [1:0] size);
        byte_mask_t m;
        case (size)
            2'd0:    m = byte_mask_t'(8'h01) << off;
            2'd1:    m = byte_mask_t'(8'h03) << {off[2:1], 1'b0};
            2'd2:    m = byte_mask_t'(8'h0F) << {off[2], 2'b00};
            default: m = byte_mask_t'(8'hFF);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/spec_load_match.sv
module spec_load_match
    import spec_load_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             ent_valid_i,
    input  logic [TAG_W-1:0] ent_tag_i,
    input  byte_mask_t       ent_mask_i,
    input  logic             sto_valid_i,
    input  logic [TAG_W-1:0] sto_tag_i,
    input  byte_mask_t       sto_mask_i,
    output logic             kill_o
);

    logic tag_eq;
    logic lanes_hit;

    always_comb begin
        tag_eq    = (ent_tag_i == sto_tag_i);
        lanes_hit = |(ent_mask_i & sto_mask_i);
        kill_o    = ent_valid_i && sto_valid_i && tag_eq && lanes_hit;
    end

endmodule

// File: rtl/spec_load_lookup.sv
module spec_load_lookup #(
    parameter int IDX_W = 5,
    parameter int HI_W  = 2,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic [ENTRIES-1:0]           live_i,
    input  logic [ENTRIES-1:0][HI_W-1:0] hi_i,
    input  logic [IDX_W+HI_W-1:0]        reg_i,
    output logic                         hit_o
);

    logic [IDX_W-1:0] idx;
    logic [HI_W-1:0]  hi_want;

    always_comb begin
        idx     = reg_i[IDX_W-1:0];
        hi_want = reg_i[IDX_W+HI_W-1:IDX_W];
        hit_o   = live_i[idx] && (hi_i[idx] == hi_want);
    end

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
    import spec_load_pkg::*;
#(
    parameter int REG_W  = 7,
    parameter int IDX_W  = 5,
    parameter int ADDR_W = 40,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              ld_valid_i,
    input  logic [REG_W-1:0]  ld_reg_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [1:0]        ld_size_i,
    input  logic              sto_valid_i,
    input  logic [ADDR_W-1:0] sto_addr_i,
    input  logic [1:0]        sto_size_i,
    input  logic              chk_valid_i,
    input  logic [REG_W-1:0]  chk_reg_i,
    output logic              chk_done_o,
    output logic              chk_ok_o
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int HI_W    = REG_W - IDX_W;
    localparam int TAG_LO  = GRAN_LG;
    localparam int TAG_TOP = TAG_LO + TAG_W;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][HI_W-1:0]  hi;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][GRAN_BYTES-1:0] mask;
        logic                          chk_done;
        logic                          chk_ok;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    logic [TAG_W-1:0]   ld_tag, sto_tag;
    byte_mask_t         ld_mask, sto_mask;
    logic [IDX_W-1:0]   ld_idx;
    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] live;
    logic               look_hit;
    logic               unused_addr_hi;

    assign ld_tag   = ld_addr_i[TAG_TOP-1:TAG_LO];
    assign sto_tag  = sto_addr_i[TAG_TOP-1:TAG_LO];
    assign ld_mask  = lane_mask(ld_addr_i[GRAN_LG-1:0], ld_size_i);
    assign sto_mask = lane_mask(sto_addr_i[GRAN_LG-1:0], sto_size_i);
    assign ld_idx   = ld_reg_i[IDX_W-1:0];
    assign unused_addr_hi = ^{ld_addr_i[ADDR_W-1:TAG_TOP], sto_addr_i[ADDR_W-1:TAG_TOP]};

    // One overlap comparator per slot.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        spec_load_match #(.TAG_W(TAG_W)) u_match (
            .ent_valid_i (tbl_q.valid[e]),
            .ent_tag_i   (tbl_q.tag[e]),
            .ent_mask_i  (tbl_q.mask[e]),
            .sto_valid_i (sto_valid_i),
            .sto_tag_i   (sto_tag),
            .sto_mask_i  (sto_mask),
            .kill_o      (kill[e])
        );
    end

    // Entries as the check sees them: same-cycle store kills already applied.
    assign live = tbl_q.valid & ~kill;

    spec_load_lookup #(.IDX_W(IDX_W), .HI_W(HI_W)) u_lookup (
        .live_i (live),
        .hi_i   (tbl_q.hi),
        .reg_i  (chk_reg_i),
        .hit_o  (look_hit)
    );

    always_comb begin
        tbl_d       = tbl_q;
        tbl_d.valid = live;
        if (ld_valid_i) begin
            tbl_d.valid[ld_idx] = 1'b1;
            tbl_d.hi[ld_idx]    = ld_reg_i[REG_W-1:IDX_W];
            tbl_d.tag[ld_idx]   = ld_tag;
            tbl_d.mask[ld_idx]  = ld_mask;
        end
        if (clear_i) begin
            tbl_d.valid = '0;
        end
        tbl_d.chk_done = chk_valid_i;
        tbl_d.chk_ok   = chk_valid_i && look_hit && !clear_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign chk_done_o = tbl_q.chk_done;
    assign chk_ok_o   = tbl_q.chk_ok;

endmodule

// File: rtl/spec_load_table_chk.sv
module spec_load_table_chk #(
    parameter int REG_W  = 7,
    parameter int ADDR_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic              ld_valid_i,
    input logic [REG_W-1:0]  ld_reg_i,
    input logic [ADDR_W-1:0] ld_addr_i,
    input logic [1:0]        ld_size_i,
    input logic              sto_valid_i,
    input logic [ADDR_W-1:0] sto_addr_i,
    input logic [1:0]        sto_size_i,
    input logic              chk_valid_i,
    input logic [REG_W-1:0]  chk_reg_i,
    input logic              chk_done_o,
    input logic              chk_ok_o
);

    logic unused_sizes;
    assign unused_sizes = ^{ld_size_i, sto_size_i};

    AST_ANSWER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_i |=> chk_done_o); // R12

    AST_NO_STRAY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid_i |=> !chk_done_o); // R12

    AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_ok_o |-> chk_done_o); // R12

    AST_FRESH_LOAD_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ld_valid_i) && !$past(clear_i) && chk_valid_i &&
         chk_reg_i == $past(ld_reg_i) && !sto_valid_i && !clear_i) |=> chk_ok_o); // R2

    AST_SAME_CYCLE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ld_valid_i) && chk_valid_i && sto_valid_i &&
         chk_reg_i == $past(ld_reg_i) && sto_addr_i == $past(ld_addr_i)) |=> !chk_ok_o); // R8

    AST_CLEAR_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid_i && clear_i) |=> !chk_ok_o); // R10

    AST_AFTER_CLEAR_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clear_i) && chk_valid_i && !$past(ld_valid_i)) |=> !chk_ok_o); // R10

endmodule

bind spec_load_table spec_load_table_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/spec_load_table_bench.sv
module spec_load_table_bench;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W  = 7;
    localparam int ADDR_W = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clear_i = 1'b0;
    logic              ld_valid_i = 1'b0;
    logic [REG_W-1:0]  ld_reg_i = '0;
    logic [ADDR_W-1:0] ld_addr_i = '0;
    logic [1:0]        ld_size_i = '0;
    logic              sto_valid_i = 1'b0;
    logic [ADDR_W-1:0] sto_addr_i = '0;
    logic [1:0]        sto_size_i = '0;
    logic              chk_valid_i = 1'b0;
    logic [REG_W-1:0]  chk_reg_i = '0;
    logic              chk_done_o;
    logic              chk_ok_o;

    typedef struct {
        bit    exp;
        string req;
        int    regid;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_load_table u_spec_load_table (.*);

    task automatic tick();
        @(posedge clk);
        #1;
        ld_valid_i  = 1'b0;
        sto_valid_i = 1'b0;
        chk_valid_i = 1'b0;
        clear_i     = 1'b0;
    endtask

    task automatic put_ld(input int r, input logic [ADDR_W-1:0] a, input int s);
        ld_valid_i = 1'b1;
        ld_reg_i   = REG_W'(r);
        ld_addr_i  = a;
        ld_size_i  = 2'(s);
    endtask

    task automatic put_st(input logic [ADDR_W-1:0] a, input int s);
        sto_valid_i = 1'b1;
        sto_addr_i  = a;
        sto_size_i  = 2'(s);
    endtask

    task automatic put_chk(input int r, input bit exp, input string req);
        item_t it;
        chk_valid_i = 1'b1;
        chk_reg_i   = REG_W'(r);
        it.exp   = exp;
        it.req   = req;
        it.regid = r;
        q.push_back(it);
    endtask

    // Monitor: compares each answer against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && chk_done_o && !finished) begin
            item_t it;
            n_checks++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL R12: unexpected answer ok=%0b, expected no answer", chk_ok_o);
            end else begin
                it = q.pop_front();
                if (chk_ok_o !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: reg %0d ok=%0b expected %0b", it.req, it.regid, chk_ok_o, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        put_chk(5, 1'b0, "R1"); tick();
        put_chk(0, 1'b0, "R1"); tick();

        // R2: recorded load survives
        put_ld(5, 40'h100, 3); tick();
        put_chk(5, 1'b1, "R2"); tick();
        // R3: shared slot index, different upper id bits
        put_chk(37, 1'b0, "R3"); tick();
        put_ld(127, 40'h1F0, 3); tick();
        put_chk(127, 1'b1, "R3"); tick();
        put_chk(31, 1'b0, "R3"); tick();

        // R5: overlapping bytes kill
        put_st(40'h104, 2); tick();
        put_chk(5, 1'b0, "R5"); tick();

        // R7: size/alignment lanes
        put_ld(6, 40'h200, 2); tick();
        put_st(40'h204, 2); tick();
        put_chk(6, 1'b1, "R7"); tick();
        put_st(40'h203, 1); tick();
        put_chk(6, 1'b0, "R7"); tick();

        // R6: aliasing above the tag slice
        put_ld(7, 40'h300, 3); tick();
        put_st(40'h300 | (40'h1 << 15), 0); tick();
        put_chk(7, 1'b0, "R6"); tick();

        // R5: different granule does not kill
        put_ld(8, 40'h400, 3); tick();
        put_st(40'h408, 3); tick();
        put_chk(8, 1'b1, "R5"); tick();

        // R4: overwrite
        put_ld(9, 40'h500, 3); tick();
        put_ld(9, 40'h600, 3); tick();
        put_st(40'h500, 3); tick();
        put_chk(9, 1'b1, "R4"); tick();
        put_st(40'h606, 0); tick();
        put_chk(9, 1'b0, "R4"); tick();

        // R8: same-cycle store and check
        put_ld(10, 40'h700, 3); tick();
        put_st(40'h700, 3); put_chk(10, 1'b0, "R8"); tick();
        put_chk(10, 1'b0, "R8"); tick();

        // R9: same-cycle load with store, load with check
        put_ld(11, 40'h800, 3); put_st(40'h800, 3); tick();
        put_chk(11, 1'b1, "R9"); tick();
        put_ld(12, 40'h900, 3); put_chk(12, 1'b0, "R9"); tick();
        put_chk(12, 1'b1, "R9"); tick();

        // R11: selective removal
        put_ld(13, 40'hA00, 3); tick();
        put_ld(14, 40'hB00, 3); tick();
        put_st(40'hA00, 3); tick();
        put_chk(13, 1'b0, "R11"); tick();
        put_chk(14, 1'b1, "R11"); tick();

        // R12: no answer in an idle cycle
        tick();
        @(negedge clk);
        n_checks++;
        if (chk_done_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R12: idle done=%0b expected 0", chk_done_o);
        end

        // R10: clear
        put_ld(15, 40'hC00, 3); tick();
        clear_i = 1'b1; put_chk(14, 1'b0, "R10"); tick();
        put_chk(15, 1'b0, "R10"); tick();
        put_ld(16, 40'hD00, 3); clear_i = 1'b1; tick();
        put_chk(16, 1'b0, "R10"); tick();
        put_ld(16, 40'hD00, 3); tick();
        put_chk(16, 1'b1, "R10"); tick();

        tick();
        tick();
        finished = 1'b1;
        n_checks++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R12: %0d answers missing, expected 0", q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule